// File: doc/BRIEF.md
# SPI Byte-Stream Master with Watermark Interrupts

This block is a single-lane SPI master driven by software as a raw byte stream. Software writes bytes into a small transmit queue. It reads the bytes that came back from a receive queue of the same depth. The engine takes one byte at a time from the transmit queue and shifts it out MSB first in SPI mode 0. In the same eight clocks it shifts one byte in from the slave. Each byte sent therefore leaves exactly one byte in the receive queue. To read a flash device, software writes the opcode, the address bytes and one dummy byte per wanted data byte. It then throws away the echoes of the command bytes. With three address bytes and four data bytes, that is eight bytes out and eight back, and the last four are the data.

Chip select goes low when the first byte leaves the transmit queue. It stays low for as long as the next byte is already queued when the current byte finishes. Because both queues are only four bytes deep, two level interrupts help software keep them serviced. One says the transmit queue has drained to its threshold or below. The other says the receive queue has filled to its threshold or above.

The engine state machine has three states. ST_IDLE has chip select high and SCLK low. ST_SCK_LO drives SCLK low with the current bit on MOSI. ST_SCK_HI drives SCLK high. The transitions are:
- ST_IDLE goes to ST_SCK_LO when a byte is queued, and that byte is loaded.
- ST_SCK_LO goes to ST_SCK_HI at the end of its half period, and MISO is sampled at that point.
- ST_SCK_HI goes back to ST_SCK_LO at the end of its half period when bits of the byte remain. It also goes to ST_SCK_LO after the eighth bit when another byte is queued, and that byte is loaded.
- ST_SCK_HI goes to ST_IDLE after the eighth bit when the transmit queue is empty.

Top module: `spi_byte_engine`

## Requirements
- R1: Each queue holds DEPTH bytes (4 by default). The transmit queue accepts four bytes while the engine is stalled in a byte, and the receive queue keeps four received bytes in arrival order.
- R2: The SPI timing is mode 0.
  - SCLK idles low, and each half period lasts CLK_DIV clocks.
  - MOSI changes only while SCLK is low.
  - MISO is sampled on the rising SCLK edge.
  - Bits go out and come in MSB first.
- R3: Every transmitted byte pushes exactly one received byte, and the received bytes leave the queue in arrival order.
- R4: Chip select stays low with no gap across consecutive bytes as long as the transmit queue is non-empty when each byte ends. An eight-byte read produces one chip-select frame of 64 SCLK pulses.
- R5: Chip select rises right after the last bit of a byte if the transmit queue is then empty. SCLK is low whenever chip select is high.
- R6: A push into a full transmit queue is dropped unless the engine takes a byte in the same cycle. A dropped push sets tx_ovf, which stays set until reset.
- R7: A byte that completes while the receive queue is full is dropped. It sets rx_ovf, which stays set until reset, and the stored bytes stay unchanged.
- R8: tx_wm_irq is high exactly while the transmit fill level is at or below tx_thresh.
- R9: rx_wm_irq is high exactly while the receive fill level is at or above rx_thresh.
- R10: After reset the state is as follows.
  - cs_n is 1, sclk is 0 and rx_valid is 0.
  - Both overflow flags are 0.
  - Both queues are empty.
- R11: rx_data shows the oldest received byte while rx_valid is 1. A pop while the receive queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Write tx_data into the transmit queue |
| tx_data | input | 8 | Byte to transmit |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| rx_valid | output | 1 | Receive queue non-empty |
| tx_thresh | input | 3 | Transmit watermark level |
| rx_thresh | input | 3 | Receive watermark level |
| tx_wm_irq | output | 1 | Transmit level at or below tx_thresh |
| rx_wm_irq | output | 1 | Receive level at or above rx_thresh |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |

## Verification
The software push and the engine's fetch can land on the same transmit-queue edge. So can the software pop and a byte completing into the receive queue.

The overflow test pushes six bytes back to back from idle, so the second push coincides with the engine taking the first byte. The expected outcome is five bytes accepted, one drop, and exactly five bytes on MOSI. One accepted byte too few or too many shows up as a wrong MOSI capture or a wrong flag.

The eight-byte read feeds and drains both queues while the engine runs. The bench judges it by a single chip-select frame, 64 captured bits and the byte order at the receive side.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCK_LO = 2'd1,
        ST_SCK_HI = 2'd2
    } eng_state_e;
endpackage

// File: rtl/byte_fifo.sv
// Small synchronous queue; DEPTH must be a power of two.
module byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          drop
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    // a full queue still takes a byte when one leaves on the same edge
    assign do_push = push && (!full || do_pop);
    assign drop    = push && !do_push;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/spi_shifter.sv
// Mode-0 byte shifter: one state register process, one output process.
module spi_shifter
    import spi_eng_pkg::*;
#(
    parameter int CLK_DIV = 2,
    localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_avail,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_take,
    output logic              rx_put,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    eng_state_e        state_q, state_d;
    logic [DIV_W-1:0]  div_q;
    logic [2:0]        bit_q;
    logic [BYTE_W-1:0] tx_sh, rx_sh;
    logic              phase_end, last_bit;

    assign phase_end = (div_q == DIV_W'(CLK_DIV - 1));
    assign last_bit  = (bit_q == 3'd7);

    always_comb begin
        state_d = state_q;
        tx_take = 1'b0;
        rx_put  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_avail) begin
                    state_d = ST_SCK_LO;
                    tx_take = 1'b1;
                end
            end
            ST_SCK_LO: begin
                if (phase_end) state_d = ST_SCK_HI;
            end
            ST_SCK_HI: begin
                if (phase_end) begin
                    if (!last_bit) begin
                        state_d = ST_SCK_LO;
                    end else begin
                        rx_put = 1'b1;
                        if (tx_avail) begin
                            state_d = ST_SCK_LO;
                            tx_take = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            div_q   <= '0;
            bit_q   <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
        end else begin
            state_q <= state_d;
            div_q   <= (state_d != state_q || phase_end) ? '0 : div_q + 1'b1;
            if (tx_take) begin
                tx_sh <= tx_byte;
                bit_q <= '0;
            end else if (state_q == ST_SCK_HI && phase_end) begin
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                bit_q <= bit_q + 1'b1;
            end
            if (state_q == ST_SCK_LO && phase_end)
                rx_sh <= {rx_sh[BYTE_W-2:0], miso};
        end
    end

    assign rx_byte = rx_sh;

    always_comb begin
        cs_n = (state_q == ST_IDLE);
        sclk = (state_q == ST_SCK_HI);
        mosi = (state_q == ST_IDLE) ? 1'b0 : tx_sh[BYTE_W-1];
    end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
    import spi_eng_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int CLK_DIV = 2,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_push,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              rx_pop,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic [CW-1:0]     tx_thresh,
    input  logic [CW-1:0]     rx_thresh,
    output logic              tx_wm_irq,
    output logic              rx_wm_irq,
    output logic              tx_ovf,
    output logic              rx_ovf,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              tx_empty, rx_empty, tx_drop, rx_drop;
    logic              eng_take, eng_put;
    logic [BYTE_W-1:0] eng_tx_byte, eng_rx_byte;

    byte_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .din(tx_data),
        .pop(eng_take), .dout(eng_tx_byte),
        .count(tx_cnt), .empty(tx_empty), .drop(tx_drop)
    );

    byte_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(eng_put), .din(eng_rx_byte),
        .pop(rx_pop), .dout(rx_data),
        .count(rx_cnt), .empty(rx_empty), .drop(rx_drop)
    );

    spi_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .tx_avail(!tx_empty), .tx_byte(eng_tx_byte), .tx_take(eng_take),
        .rx_put(eng_put), .rx_byte(eng_rx_byte),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_ovf <= 1'b0;
            rx_ovf <= 1'b0;
        end else begin
            tx_ovf <= tx_ovf | tx_drop;
            rx_ovf <= rx_ovf | rx_drop;
        end
    end

    assign rx_valid  = !rx_empty;
    assign tx_wm_irq = (tx_cnt <= tx_thresh);
    assign rx_wm_irq = (rx_cnt >= rx_thresh);
endmodule

// File: rtl/spi_byte_engine_chk.sv
module spi_byte_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic cs_n,
    input logic mosi,
    input logic tx_push,
    input logic tx_ovf,
    input logic rx_ovf
);
    assert_sclk_low_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_mosi_held_while_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_tx_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |=> tx_ovf);

    assert_tx_ovf_needs_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ovf) |-> $past(tx_push));

    assert_rx_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |=> rx_ovf);

    assert_rx_ovf_at_byte_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovf) |-> $past(sclk));
endmodule

bind spi_byte_engine spi_byte_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .tx_push(tx_push), .tx_ovf(tx_ovf), .rx_ovf(rx_ovf)
);

// File: tb/tb_spi_byte_engine.sv
module tb_spi_byte_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam logic [7:0] VEC [NVEC] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h01, 8'h3C, 8'hC3};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_data = '0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic [2:0] tx_thresh = '0, rx_thresh = 3'd1;
    logic       tx_wm_irq, rx_wm_irq, tx_ovf, rx_ovf;
    logic       sclk, cs_n, mosi, miso;
    logic       inv = 1'b0;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] cap [32];
    int cap_n = 0, bits = 0, cs_rises = 0;
    logic [7:0] mon_sh = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign miso = mosi ^ inv;   // loopback slave, optionally inverting

    spi_byte_engine dut (
        .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_data(tx_data),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .tx_wm_irq(tx_wm_irq), .rx_wm_irq(rx_wm_irq),
        .tx_ovf(tx_ovf), .rx_ovf(rx_ovf),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always @(posedge sclk) if (rst_n && !cs_n) begin
        mon_sh = {mon_sh[6:0], mosi};
        bits++;
        if (bits % 8 == 0 && cap_n < 32) begin
            cap[cap_n] = mon_sh;
            cap_n++;
        end
    end
    always @(posedge cs_n) if (rst_n) cs_rises++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tx_push = 0; rx_pop = 0;
        repeat (3) @(negedge clk);
        cap_n = 0; bits = 0; cs_rises = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push_byte(input logic [7:0] b);
        tx_push = 1'b1; tx_data = b;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (!cs_n) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10 reset state
        chk(cs_n == 1'b1, "R10 cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R10 sclk", sclk, 0);
        chk(rx_valid == 1'b0, "R10 rx_valid", rx_valid, 0);
        chk(tx_ovf == 1'b0 && rx_ovf == 1'b0, "R10 ovf", {tx_ovf, rx_ovf}, 0);
        chk(tx_wm_irq == 1'b1, "R8 empty tx at thresh 0", tx_wm_irq, 1);
        chk(rx_wm_irq == 1'b0, "R9 empty rx below thresh 1", rx_wm_irq, 0);

        // R11 pop on empty has no effect
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0; @(negedge clk);
        chk(rx_valid == 1'b0, "R11 pop on empty", rx_valid, 0);

        // table walk: inverted loopback, one byte per frame
        inv = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            int c0;
            c0 = cs_rises;
            push_byte(VEC[i]);
            wait_idle();
            chk(cap[cap_n-1] == VEC[i], "R2 mosi msb first", cap[cap_n-1], VEC[i]);
            chk(rx_valid && rx_data == ~VEC[i], "R3 echo byte", rx_data, ~VEC[i]);
            chk(cs_rises == c0 + 1, "R5 cs released", cs_rises, c0 + 1);
            chk(rx_wm_irq == 1'b1, "R9 level 1 at thresh 1", rx_wm_irq, 1);
            rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
            chk(!rx_valid && !rx_wm_irq, "R11 pop empties", {rx_valid, rx_wm_irq}, 0);
        end
        chk(bits == 8 * NVEC, "R2 sclk pulses", bits, 8 * NVEC);

        // R4 eight-byte read in one frame
        begin
            logic [7:0] seq [8];
            logic [7:0] got [8];
            int c0, b0;
            seq = '{8'h03, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00, 8'h00};
            c0 = cs_rises; b0 = bits;
            tx_thresh = 3'd3;
            fork
                for (int k = 0; k < 8; k++) begin
                    while (!tx_wm_irq) @(negedge clk);
                    push_byte(seq[k]);
                end
                begin
                    int n = 0;
                    while (n < 8) begin
                        @(negedge clk);
                        rx_pop = 1'b0;
                        if (rx_valid) begin
                            got[n] = rx_data;
                            n++;
                            rx_pop = 1'b1;
                        end
                    end
                    @(negedge clk);
                    rx_pop = 1'b0;
                end
            join
            wait_idle();
            chk(cs_rises == c0 + 1, "R4 single frame", cs_rises, c0 + 1);
            chk(bits - b0 == 64, "R4 64 bits", bits - b0, 64);
            chk(got[0] == 8'hFC, "R3 opcode echo", got[0], 8'hFC);
            for (int k = 4; k < 8; k++)
                chk(got[k] == 8'hFF, "R3 data bytes", got[k], 8'hFF);
            chk(tx_ovf == 1'b0, "R6 no drop while fed", tx_ovf, 0);
        end

        // R6 R7 R1 overflow from idle with six back-to-back pushes
        do_reset();
        inv = 1'b0;
        tx_thresh = 3'd3; rx_thresh = 3'd4;
        for (int k = 0; k < 6; k++) begin
            tx_push = 1'b1; tx_data = 8'h10 + 8'(k);
            @(negedge clk);
        end
        tx_push = 1'b0;
        chk(tx_ovf == 1'b1, "R6 sixth push dropped", tx_ovf, 1);
        chk(tx_wm_irq == 1'b0, "R8 level 4 above thresh 3", tx_wm_irq, 0);
        wait_idle();
        chk(cap_n == 5, "R1 five bytes sent", cap_n, 5);
        chk(cap[4] == 8'h14, "R6 last accepted byte", cap[4], 8'h14);
        chk(rx_ovf == 1'b1, "R7 fifth rx dropped", rx_ovf, 1);
        chk(rx_wm_irq == 1'b1, "R9 full at thresh 4", rx_wm_irq, 1);
        chk(tx_wm_irq == 1'b1, "R8 drained", tx_wm_irq, 1);
        for (int k = 0; k < 4; k++) begin
            chk(rx_valid && rx_data == 8'h10 + 8'(k), "R7 stored bytes kept", rx_data, 8'h10 + 8'(k));
            rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
        end
        chk(rx_valid == 1'b0, "R1 four stored", rx_valid, 0);
        chk(tx_ovf && rx_ovf, "R6 R7 sticky", {tx_ovf, rx_ovf}, 3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule